// File: doc/BRIEF.md
# Write-Through Data Cache with Posted Store Queue

This block is a direct-mapped data cache placed between one requester and a slower word-wide memory port. Loads that hit are answered from the cache one cycle after acceptance. Every store is copied into a small posted queue, and the requester gets its acknowledgement at once. The queue then sends the stores to memory by itself, oldest first. When a store hits, it also updates the cached line. No line is ever dirty, so when a line is replaced it is simply overwritten.

On a load miss the cache fetches the whole line, one word at a time. While the fill is in progress, the queue stops draining. Each returned word is patched with any queued stores to the same word address before it is written into the line and returned. A load that follows a store that is still queued therefore always sees the stored data.

Both sides use valid/ready requests. The requester and memory addresses are word addresses. The line offset is in the low bits, the line index sits above it, and the tag is in the high bits.

Top module: `wt_posted_cache`

## Requirements
- R1: After reset, every line is invalid, the store queue is empty, `req_ready` is high, and both `mem_req_valid` and `rsp_valid` are low.
- R2: A load that hits is answered with `rsp_valid` high in the cycle after it is accepted, and it causes no memory read.
- R3: A store is accepted in the cycle it is offered whenever the queue has room, even if memory is not ready. Each accepted store later appears exactly once on the memory port as a write (`mem_req_write` = 1) with the same address, data and byte enables.
- R4: A store that hits updates only the bytes of the cached word whose byte enable is set (bit b covers data bits 8b+7..8b). A later load of that word hits and returns the patched word.
- R5: A store that misses does not allocate a line, so a later load of that address misses and fetches the line.
- R6: Queued stores reach memory in the order in which they were accepted.
- R7: When the queue holds its maximum number of entries, `req_ready` is low for stores until an entry has drained.
- R8: A load miss issues exactly one read per word of the line, in ascending offset order, and no queued store is sent to memory until the fill is complete.
- R9: Before a fetched word is used, the queued stores to the same word address are applied to it byte by byte, from oldest to youngest, so that the youngest store wins. The patched word is returned to the requester and also kept in the line.
- R10: When a miss replaces a valid line, no write is issued for the old line. Its data is read back correctly from memory later.
- R11: Stores never produce a response on `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Requester access valid |
| req_ready | output | 1 | Access accepted this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data |
| req_be | input | DW/8 | Store byte enables |
| rsp_valid | output | 1 | Load data valid (one-cycle pulse) |
| rsp_rdata | output | DW | Load data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write of a queued store, 0 = line read |
| mem_req_addr | output | AW | Memory word address |
| mem_req_wdata | output | DW | Write data |
| mem_req_be | output | DW/8 | Write byte enables (all ones for reads) |
| mem_rsp_valid | input | 1 | Read data returned, in request order |
| mem_rsp_rdata | input | DW | Read data |

## Verification
Loads are applied in several situations:
- a cold line, which separates a miss from a hit by the number of memory reads;
- a word of a line already filled, which gives the one-cycle hit latency;
- a word patched by an earlier store hit, which shows the in-cache byte merge;
- an address whose stores are still queued behind a stalled memory, with two overlapping partial stores to one word, which separates youngest-wins forwarding from stale memory data.

Stores are applied while memory is stalled, to expose the acknowledgement that does not wait for memory, the full-queue backpressure and the drain order. A conflicting miss on the same index shows that eviction causes no write traffic.

// File: rtl/wt_posted_cache.sv
module wt_posted_cache #(
  parameter int AW    = 12,
  parameter int DW    = 32,
  parameter int LINES = 16,
  parameter int WORDS = 4,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [DW/8-1:0] req_be,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic [AW-1:0]   mem_req_addr,
  output logic [DW-1:0]   mem_req_wdata,
  output logic [DW/8-1:0] mem_req_be,
  input  logic            mem_rsp_valid,
  input  logic [DW-1:0]   mem_rsp_rdata
);
  localparam int BW = DW / 8;
  localparam int OW = $clog2(WORDS);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW - OW;
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  typedef enum logic {S_IDLE, S_FILL} state_e;

  logic [DW-1:0]    data_q [LINES*WORDS];
  logic [TW-1:0]    tag_q  [LINES];
  logic [LINES-1:0] vld_q;

  logic [AW-1:0] f_addr [DEPTH];
  logic [DW-1:0] f_data [DEPTH];
  logic [BW-1:0] f_be   [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  state_e        st;
  logic [TW-1:0] m_tag;
  logic [IW-1:0] m_idx;
  logic [OW-1:0] m_off, rsp_cnt;
  logic [OW:0]   req_cnt;
  logic [DW-1:0] hold_q, merged;

  logic [TW-1:0] r_tag;
  logic [IW-1:0] r_idx;
  logic [OW-1:0] r_off;
  logic idle, hit, full, acc, push, rd_acc, pop, fill_beat, last_beat;
  logic [AW-1:0] fill_word;

  assign r_tag = req_addr[AW-1 -: TW];
  assign r_idx = req_addr[OW +: IW];
  assign r_off = req_addr[OW-1:0];
  assign idle  = (st == S_IDLE);
  assign hit   = vld_q[r_idx] && (tag_q[r_idx] == r_tag);
  assign full  = (cnt == CW'(DEPTH));

  assign req_ready = idle && !(req_write && full);
  assign acc       = req_valid && req_ready;
  assign push      = acc && req_write;
  assign rd_acc    = acc && !req_write;

  assign mem_req_valid = idle ? (cnt != '0) : !req_cnt[OW];
  assign mem_req_write = idle;
  assign mem_req_addr  = idle ? f_addr[rd_ptr] : {m_tag, m_idx, req_cnt[OW-1:0]};
  assign mem_req_wdata = f_data[rd_ptr];
  assign mem_req_be    = idle ? f_be[rd_ptr] : '1;
  assign pop           = idle && (cnt != '0) && mem_req_ready;

  assign fill_beat = !idle && mem_rsp_valid;
  assign last_beat = fill_beat && (rsp_cnt == OW'(WORDS-1));
  assign fill_word = {m_tag, m_idx, rsp_cnt};

  always_comb begin
    merged = mem_rsp_rdata;
    for (int k = 0; k < DEPTH; k++) begin
      if (CW'(k) < cnt && f_addr[rd_ptr + PW'(k)] == fill_word) begin
        for (int b = 0; b < BW; b++) begin
          if (f_be[rd_ptr + PW'(k)][b]) merged[8*b +: 8] = f_data[rd_ptr + PW'(k)][8*b +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      vld_q     <= '0;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      cnt       <= '0;
      rsp_valid <= 1'b0;
      req_cnt   <= '0;
      rsp_cnt   <= '0;
      m_tag     <= '0;
      m_idx     <= '0;
      m_off     <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
      if (rd_acc) begin
        if (hit) begin
          rsp_valid <= 1'b1;
        end else begin
          st           <= S_FILL;
          m_tag        <= r_tag;
          m_idx        <= r_idx;
          m_off        <= r_off;
          req_cnt      <= '0;
          rsp_cnt      <= '0;
          vld_q[r_idx] <= 1'b0;
        end
      end
      if (!idle && mem_req_valid && mem_req_ready) req_cnt <= req_cnt + 1'b1;
      if (fill_beat) begin
        rsp_cnt <= rsp_cnt + 1'b1;
        if (last_beat) begin
          st           <= S_IDLE;
          vld_q[m_idx] <= 1'b1;
          rsp_valid    <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      f_addr[wr_ptr] <= req_addr;
      f_data[wr_ptr] <= req_wdata;
      f_be[wr_ptr]   <= req_be;
      if (hit) begin
        for (int b = 0; b < BW; b++) begin
          if (req_be[b]) data_q[{r_idx, r_off}][8*b +: 8] <= req_wdata[8*b +: 8];
        end
      end
    end
    if (rd_acc && hit) rsp_rdata <= data_q[{r_idx, r_off}];
    if (fill_beat) begin
      data_q[{m_idx, rsp_cnt}] <= merged;
      if (rsp_cnt == m_off) hold_q <= merged;
    end
    if (last_beat) begin
      tag_q[m_idx] <= m_tag;
      rsp_rdata    <= (rsp_cnt == m_off) ? merged : hold_q;
    end
  end

  a_r7_full_blocks_store: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH) && req_valid && req_write) |-> !req_ready);
  a_r8_fill_no_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && mem_req_valid) |-> !mem_req_write);
  a_r11_store_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> !rsp_valid);
  a_r3_store_queued: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> (cnt != '0));
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
endmodule

// File: tb/wt_posted_cache_bench.sv
module wt_posted_cache_bench;
  localparam int AW = 12, DW = 32, BW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid, req_ready, req_write, rsp_valid;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, rsp_rdata;
  logic [BW-1:0] req_be;
  logic mem_req_valid, mem_req_ready, mem_req_write, mem_rsp_valid;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata, mem_rsp_rdata;
  logic [BW-1:0] mem_req_be;

  wt_posted_cache u_wt_posted_cache (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_wdata, .req_be,
    .rsp_valid, .rsp_rdata, .mem_req_valid, .mem_req_ready, .mem_req_write,
    .mem_req_addr, .mem_req_wdata, .mem_req_be, .mem_rsp_valid, .mem_rsp_rdata
  );

  int vectors = 0, errors = 0, cyc = 0, rd_cnt = 0, wr_cnt = 0;
  int acc_cyc = 0, last_lat = 0, rsp_rd = 0, rsp_wr = 0, spurious = 0, st_wait = 0;
  logic [DW-1:0] bmem [1<<AW];
  logic [DW-1:0] ref_mem [1<<AW];
  logic [AW+DW+BW-1:0] exp_w [$];
  logic [DW-1:0] exp_r [$];
  logic [AW-1:0] rd_log [$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic [AW+DW+BW-1:0] e;
    cyc++;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        wr_cnt++;
        if (exp_w.size() == 0) begin
          chk("R3 unexpected memory write", {16'h0, mem_req_addr, mem_req_wdata, mem_req_be}, 64'h0);
        end else begin
          e = exp_w.pop_front();
          chk("R6 R3 drained store (addr,data,be)", {16'h0, mem_req_addr, mem_req_wdata, mem_req_be}, {16'h0, e});
        end
        for (int b = 0; b < BW; b++)
          if (mem_req_be[b]) bmem[mem_req_addr][8*b +: 8] <= mem_req_wdata[8*b +: 8];
      end else begin
        rd_cnt++;
        rd_log.push_back(mem_req_addr);
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= bmem[mem_req_addr];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      last_lat = cyc - acc_cyc;
      rsp_rd = rd_cnt;
      rsp_wr = wr_cnt;
      if (exp_r.size() == 0) begin
        spurious++;
        chk("R11 response without a load", {32'h0, rsp_rdata}, 64'h0);
      end else begin
        chk("R9 R2 load data", {32'h0, rsp_rdata}, {32'h0, exp_r.pop_front()});
      end
    end
  end

  task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BW-1:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
    st_wait = 0;
    while (!req_ready) begin @(negedge clk); st_wait++; end
    exp_w.push_back({a, d, be});
    for (int b = 0; b < BW; b++) if (be[b]) ref_mem[a][8*b +: 8] = d[8*b +: 8];
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic load_issue(input logic [AW-1:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    exp_r.push_back(ref_mem[a]);
    acc_cyc = cyc;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic load_wait();
    while (exp_r.size() != 0) @(negedge clk);
  endtask

  task automatic wait_drain();
    while (exp_w.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (run did not complete) actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int r0, w0;
    for (int i = 0; i < (1<<AW); i++) begin
      bmem[i] = (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0000;
      ref_mem[i] = bmem[i];
    end
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
    mem_req_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs {req_ready,mem_req_valid,rsp_valid}", {61'h0, req_ready, mem_req_valid, rsp_valid}, 64'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset outputs", {61'h0, req_ready, mem_req_valid, rsp_valid}, 64'h4);

    // R8: cold miss fetches the line in order
    rd_log.delete();
    r0 = rd_cnt;
    load_issue(12'h010); load_wait();
    chk("R1 R8 cold miss read count", 64'(rsp_rd - r0), 64'd4);
    chk("R8 fill order", {16'h0, rd_log[0], rd_log[1], rd_log[2], rd_log[3]}, {16'h0, 12'h010, 12'h011, 12'h012, 12'h013});

    // R2: hit
    r0 = rd_cnt;
    load_issue(12'h012); load_wait();
    chk("R2 hit read count", 64'(rsp_rd - r0), 64'd0);
    chk("R2 hit latency", 64'(last_lat), 64'd1);

    // R4: store hit patches bytes
    store(12'h011, 32'hDEADBEEF, 4'b0101);
    repeat (2) @(negedge clk);
    chk("R11 store gives no response", 64'(spurious), 64'd0);
    r0 = rd_cnt;
    load_issue(12'h011); load_wait();
    chk("R4 patched word served from cache", 64'(rsp_rd - r0), 64'd0);
    wait_drain();

    // R5: store miss does not allocate
    store(12'h0A0, 32'h01020304, 4'b1111);
    wait_drain();
    r0 = rd_cnt;
    load_issue(12'h0A0); load_wait();
    chk("R5 load after store miss fetches line", 64'(rsp_rd - r0), 64'd4);

    // R3 / R7: posted stores and full queue
    mem_req_ready = 1'b0;
    store(12'h0B0, 32'hA0A0A0A0, 4'b1111);
    chk("R3 store accepted while memory stalled", 64'(st_wait), 64'd0);
    store(12'h0B1, 32'hB1B1B1B1, 4'b0011);
    store(12'h0B2, 32'hC2C2C2C2, 4'b1100);
    store(12'h0B0, 32'hD3D3D3D3, 4'b0001);
    chk("R3 fourth store accepted", 64'(st_wait), 64'd0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h0B3; req_wdata = 32'hE4E4E4E4; req_be = 4'b1111;
    @(negedge clk);
    chk("R7 ready low when queue full", {63'h0, req_ready}, 64'h0);
    repeat (3) @(negedge clk);
    chk("R7 ready stays low while nothing drains", {63'h0, req_ready}, 64'h0);
    mem_req_ready = 1'b1;
    while (!req_ready) @(negedge clk);
    exp_w.push_back({12'h0B3, 32'hE4E4E4E4, 4'b1111});
    ref_mem[12'h0B3] = 32'hE4E4E4E4;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wait_drain();
    chk("R6 all queued stores drained", 64'(exp_w.size()), 64'd0);

    // R9: forwarding from queued stores during a fill
    mem_req_ready = 1'b0;
    store(12'h0C4, 32'h11223344, 4'b0011);
    store(12'h0C4, 32'hAABBCCDD, 4'b0110);
    store(12'h0C5, 32'h55667788, 4'b1000);
    w0 = wr_cnt;
    load_issue(12'h0C4);
    mem_req_ready = 1'b1;
    load_wait();
    chk("R8 no store drained during fill", 64'(rsp_wr - w0), 64'd0);
    chk("R9 youngest-wins merged word", {32'h0, ref_mem[12'h0C4]},
        {32'h0, bmem[12'h0C4][31:24], 8'hBB, 8'hCC, 8'h44});
    r0 = rd_cnt;
    load_issue(12'h0C5); load_wait();
    chk("R9 merged neighbour word kept in line", 64'(rsp_rd - r0), 64'd0);
    wait_drain();

    // R10: eviction without write-back
    w0 = wr_cnt; r0 = rd_cnt;
    load_issue(12'h050); load_wait();
    chk("R10 no write on eviction", 64'(rsp_wr - w0), 64'd0);
    chk("R10 conflicting miss read count", 64'(rsp_rd - r0), 64'd4);
    r0 = rd_cnt;
    load_issue(12'h011); load_wait();
    chk("R10 evicted word refetched", 64'(rsp_rd - r0), 64'd4);

    repeat (4) @(negedge clk);
    chk("R11 no stray responses", 64'(spurious), 64'd0);
    finish_run();
  end
endmodule